// File: doc/BRIEF.md
# PLL Retune Sequencer

This block retunes one of three on-chip PLLs (CPU, memory, bus) on a single request. The requester presents a clock index and two 32-bit configuration words and pulses `start_i`. The sequencer then owns a global PLL control word. That word carries one enable bit per PLL, a status flag per PLL read from the analog side, and the select bit of the CPU clock-source multiplexer. The sequencer steps through a fixed handshake: turn the target PLL off, load its two configuration registers, turn it back on, and poll its status flag until the PLL reports lock.

The CPU PLL needs extra care because the processor itself runs from it. Before the PLL is touched, the multiplexer select is cleared so that the CPU runs from the bus clock. After lock, a fixed settle interval must elapse before the select is set back to the PLL. Memory and bus retunes skip both steps.

The requester sees `busy_o` for the whole sequence and a one-cycle `done_o` at the end. A one-cycle `err_o` means the request was rejected or the lock wait timed out.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset, `glb_o` bits 2:0 (enables) read 1, bit 12 (CPU mux select, 1 = PLL clock) reads 1, both configuration outputs read zero, and `busy_o`, `done_o` and `err_o` read 0.
- R2: A start request is taken only while idle. A `start_i` pulse while busy changes neither the target nor the words being written.
- R3: For clock index 0 (CPU), the mux select is cleared one cycle before the CPU enable (`glb_o` bit 0) is cleared. The enable bit for index 0 is bit 0, for index 2 (bus) it is bit 1, and for index 1 (memory) it is bit 2.
- R4: Only the target PLL's enable is ever low, and it is low while its words are loaded. Word 0 goes to `cfg0_o[32*idx +: 32]` and, one cycle later, word 1 goes to `cfg1_o[32*idx +: 32]`. The other PLLs' words are untouched.
- R5: After both writes the enable is set again. The sequencer stays in its wait while the target's status flag (`pll_stat_i` in enable-bit order, mirrored on `glb_o` bits 10:8) reads 1, and leaves the wait on the first cycle it reads 0.
- R6: For a CPU retune, the mux select returns to 1 exactly SETTLE_CYCLES cycles after the wait ends. `done_o` pulses 8 cycles plus the status-high time plus SETTLE_CYCLES after the start edge.
- R7: Memory and bus retunes never change the mux select. They end with `done_o` 6 cycles plus the status-high time after the start edge.
- R8: `done_o` is a single-cycle pulse issued as `busy_o` falls. `busy_o` stays 1 from the cycle after the start edge until that pulse.
- R9: A start with clock index 3 gives a one-cycle `err_o` on the next cycle, leaves `busy_o` at 0, and changes no enable, mux or configuration bit.
- R10: If the status flag is still 1 after WAIT_LIMIT polls, `err_o` pulses, no `done_o` is issued, the block returns to idle with the target enabled, and a CPU target stays on the bus clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Retune request pulse |
| sel_i | input | 2 | Clock index: 0 CPU, 1 memory, 2 bus, 3 invalid |
| word0_i | input | 32 | First configuration word |
| word1_i | input | 32 | Second configuration word |
| pll_stat_i | input | 3 | Per-PLL status flag, enable-bit order; 1 = not yet locked |
| glb_o | output | 32 | Global control word: enables, status mirror, mux select |
| cfg0_o | output | 96 | First configuration register of each PLL, by clock index |
| cfg1_o | output | 96 | Second configuration register of each PLL, by clock index |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle rejection or timeout pulse |

## Verification
The assertions check the following on every cycle:
- at most one PLL is disabled at a time, and configuration writes land only while the target is disabled;
- the CPU enable never falls unless the CPU is already parked;
- memory and bus sequences leave the mux alone, and a start while busy does not disturb the latched request;
- `done_o` is a lone pulse seen only in idle.

Only the bench scenarios can show the rest: the exact completion latency including the settle interval, which configuration register ends up holding which word across every index and several patterns, that an invalid index leaves every output bit as it was, and the parked outcome of a CPU lock timeout.

// File: rtl/pll_retune_pkg.sv
package pll_retune_pkg;
    localparam int NUM_PLL  = 3;
    localparam int WORD_W   = 32;
    localparam int GLB_W    = 32;
    localparam int STAT_LSB = 8;
    localparam int MUX_BIT  = 12;

    typedef enum logic [1:0] {
        SEL_CPU = 2'd0,
        SEL_MEM = 2'd1,
        SEL_BUS = 2'd2,
        SEL_BAD = 2'd3
    } pll_sel_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PARK,
        ST_DIS,
        ST_WR0,
        ST_WR1,
        ST_EN,
        ST_WAIT,
        ST_SETTLE,
        ST_UNPARK,
        ST_FINISH
    } seq_state_e;

    // clock index -> one-hot position in the enable / status fields
    function automatic logic [NUM_PLL-1:0] sel_to_mask(input logic [1:0] sel);
        case (sel)
            2'd0:    sel_to_mask = 3'b001;
            2'd1:    sel_to_mask = 3'b100;
            2'd2:    sel_to_mask = 3'b010;
            default: sel_to_mask = 3'b000;
        endcase
    endfunction
endpackage

// File: rtl/pll_cfg_bank.sv
module pll_cfg_bank
    import pll_retune_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr0_i,
    input  logic                      wr1_i,
    input  logic [1:0]                sel_i,
    input  logic [WORD_W-1:0]         data_i,
    output logic [NUM_PLL*WORD_W-1:0] cfg0_o,
    output logic [NUM_PLL*WORD_W-1:0] cfg1_o
);
    for (genvar g = 0; g < NUM_PLL; g++) begin : g_pll
        logic [WORD_W-1:0] c0_d, c0_q, c1_d, c1_q;
        logic              hit;

        assign hit = (sel_i == 2'(g));

        always_comb begin
            c0_d = c0_q;
            c1_d = c1_q;
            if (wr0_i && hit) c0_d = data_i;
            if (wr1_i && hit) c1_d = data_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                c0_q <= '0;
                c1_q <= '0;
            end else begin
                c0_q <= c0_d;
                c1_q <= c1_d;
            end
        end

        assign cfg0_o[g*WORD_W +: WORD_W] = c0_q;
        assign cfg1_o[g*WORD_W +: WORD_W] = c1_q;
    end

    // R4: the two words go out on separate cycles and never to the invalid index
    p_one_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr0_i && wr1_i));
    p_valid_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0_i || wr1_i) |-> (sel_i != 2'd3));
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
    import pll_retune_pkg::*;
#(
    parameter int SETTLE_CYCLES = 12288,
    parameter int WAIT_LIMIT    = 65536
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [1:0]         sel_i,
    input  logic [WORD_W-1:0]  word0_i,
    input  logic [WORD_W-1:0]  word1_i,
    input  logic [NUM_PLL-1:0] stat_i,
    output logic [NUM_PLL-1:0] en_o,
    output logic               mux_o,
    output logic               wr0_o,
    output logic               wr1_o,
    output logic [1:0]         wr_sel_o,
    output logic [WORD_W-1:0]  wr_data_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o
);
    localparam int CNT_MAX = (SETTLE_CYCLES > WAIT_LIMIT) ? SETTLE_CYCLES : WAIT_LIMIT;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
    localparam logic [CNT_W-1:0] WAIT_LAST   = CNT_W'(WAIT_LIMIT - 1);

    typedef struct packed {
        seq_state_e         st;
        logic [1:0]         sel;
        logic [WORD_W-1:0]  w0;
        logic [WORD_W-1:0]  w1;
        logic [NUM_PLL-1:0] en;
        logic               mux;
        logic [CNT_W-1:0]   cnt;
        logic               done;
        logic               err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic [NUM_PLL-1:0] tgt_mask;
    logic               tgt_pending;
    logic               is_cpu;

    assign tgt_mask    = sel_to_mask(r_q.sel);
    assign tgt_pending = |(stat_i & tgt_mask);
    assign is_cpu      = (r_q.sel == SEL_CPU);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (sel_i == SEL_BAD) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.sel = sel_i;
                        r_d.w0  = word0_i;
                        r_d.w1  = word1_i;
                        r_d.st  = (sel_i == SEL_CPU) ? ST_PARK : ST_DIS;
                    end
                end
            end
            ST_PARK: begin
                r_d.mux = 1'b0;
                r_d.st  = ST_DIS;
            end
            ST_DIS: begin
                r_d.en = r_q.en & ~tgt_mask;
                r_d.st = ST_WR0;
            end
            ST_WR0:  r_d.st = ST_WR1;
            ST_WR1:  r_d.st = ST_EN;
            ST_EN: begin
                r_d.en  = r_q.en | tgt_mask;
                r_d.cnt = '0;
                r_d.st  = ST_WAIT;
            end
            ST_WAIT: begin
                if (!tgt_pending) begin
                    r_d.cnt = '0;
                    r_d.st  = is_cpu ? ST_SETTLE : ST_FINISH;
                end else if (r_q.cnt == WAIT_LAST) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_SETTLE: begin
                if (r_q.cnt == SETTLE_LAST) r_d.st = ST_UNPARK;
                else                        r_d.cnt = r_q.cnt + CNT_W'(1);
            end
            ST_UNPARK: begin
                r_d.mux = 1'b1;
                r_d.st  = ST_FINISH;
            end
            ST_FINISH: begin
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.sel  <= 2'd0;
            r_q.w0   <= '0;
            r_q.w1   <= '0;
            r_q.en   <= '1;
            r_q.mux  <= 1'b1;
            r_q.cnt  <= '0;
            r_q.done <= 1'b0;
            r_q.err  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign en_o      = r_q.en;
    assign mux_o     = r_q.mux;
    assign wr0_o     = (r_q.st == ST_WR0);
    assign wr1_o     = (r_q.st == ST_WR1);
    assign wr_sel_o  = r_q.sel;
    assign wr_data_o = (r_q.st == ST_WR0) ? r_q.w0 : r_q.w1;
    assign busy_o    = (r_q.st != ST_IDLE);
    assign done_o    = r_q.done;
    assign err_o     = r_q.err;

    p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE && start_i) |=> ($stable(r_q.sel) && $stable(r_q.w0) && $stable(r_q.w1)));

    p_park_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.en[0]) |-> !r_q.mux);

    p_one_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~r_q.en) <= 1);

    p_write_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0_o || wr1_o) |-> ((r_q.en & tgt_mask) == '0));

    p_wait_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT && tgt_pending) |=> (r_q.st == ST_WAIT || r_q.err));

    p_unpark_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.mux) |-> r_q.en[0]);

    p_mux_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE && r_q.sel != SEL_CPU) |=> $stable(r_q.mux));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |-> (r_q.st == ST_IDLE));

    p_bad_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && start_i && sel_i == SEL_BAD) |=>
            (r_q.err && r_q.st == ST_IDLE && $stable(r_q.en) && $stable(r_q.mux)));

    p_wait_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT) |-> (r_q.cnt <= WAIT_LAST));
endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
    import pll_retune_pkg::*;
#(
    parameter int SETTLE_CYCLES = 12288,
    parameter int WAIT_LIMIT    = 65536
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [1:0]                sel_i,
    input  logic [WORD_W-1:0]         word0_i,
    input  logic [WORD_W-1:0]         word1_i,
    input  logic [NUM_PLL-1:0]        pll_stat_i,
    output logic [GLB_W-1:0]          glb_o,
    output logic [NUM_PLL*WORD_W-1:0] cfg0_o,
    output logic [NUM_PLL*WORD_W-1:0] cfg1_o,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      err_o
);
    logic [NUM_PLL-1:0] en_w;
    logic               mux_w;
    logic               wr0_w, wr1_w;
    logic [1:0]         wr_sel_w;
    logic [WORD_W-1:0]  wr_data_w;

    pll_seq_ctrl #(
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .WAIT_LIMIT    (WAIT_LIMIT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .sel_i     (sel_i),
        .word0_i   (word0_i),
        .word1_i   (word1_i),
        .stat_i    (pll_stat_i),
        .en_o      (en_w),
        .mux_o     (mux_w),
        .wr0_o     (wr0_w),
        .wr1_o     (wr1_w),
        .wr_sel_o  (wr_sel_w),
        .wr_data_o (wr_data_w),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .err_o     (err_o)
    );

    pll_cfg_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr0_i  (wr0_w),
        .wr1_i  (wr1_w),
        .sel_i  (wr_sel_w),
        .data_i (wr_data_w),
        .cfg0_o (cfg0_o),
        .cfg1_o (cfg1_o)
    );

    always_comb begin
        glb_o                                = '0;
        glb_o[NUM_PLL-1:0]                   = en_w;
        glb_o[STAT_LSB +: NUM_PLL]           = pll_stat_i;
        glb_o[MUX_BIT]                       = mux_w;
    end
endmodule

// File: tb/pll_retune_seq_bench.sv
`timescale 1ns/100ps
module pll_retune_seq_bench;
    localparam int LOCK   = 5;
    localparam int SETTLE = 20;
    localparam int TMO    = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  sel_i = 2'd0;
    logic [31:0] word0_i = '0, word1_i = '0;
    logic [2:0]  pll_stat_i;
    logic [31:0] glb_o;
    logic [95:0] cfg0_o, cfg1_o;
    logic        busy_o, done_o, err_o;

    int checks = 0;
    int errors = 0;
    int lk [3];
    logic [2:0] stuck = 3'b000;
    logic [31:0] e0 [3];
    logic [31:0] e1 [3];

    always #2.5 clk = ~clk;

    pll_retune_seq #(.SETTLE_CYCLES(SETTLE), .WAIT_LIMIT(TMO)) u_pll_retune_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_i(sel_i),
        .word0_i(word0_i), .word1_i(word1_i), .pll_stat_i(pll_stat_i),
        .glb_o(glb_o), .cfg0_o(cfg0_o), .cfg1_o(cfg1_o),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

    // lock-delay model: flag high while disabled, then LOCK cycles after enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) lk[i] <= 0;
        end else begin
            for (int i = 0; i < 3; i++) begin
                if (!glb_o[i])                   lk[i] <= LOCK;
                else if (lk[i] != 0 && !stuck[i]) lk[i] <= lk[i] - 1;
            end
        end
    end
    always_comb for (int i = 0; i < 3; i++) pll_stat_i[i] = (lk[i] != 0);

    function automatic int bit_of(input int s);
        return (s == 0) ? 0 : ((s == 1) ? 2 : 1);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_cfg(input string req);
        for (int i = 0; i < 3; i++) begin
            chk(cfg0_o[i*32 +: 32] == e0[i], req, "cfg0 word", cfg0_o[i*32 +: 32], e0[i]);
            chk(cfg1_o[i*32 +: 32] == e1[i], req, "cfg1 word", cfg1_o[i*32 +: 32], e1[i]);
        end
    endtask

    task automatic run_retune(input int s, input logic [31:0] w0, input logic [31:0] w1,
                              input bit intrude);
        int n = 0, done_n = 0, mux_rise = 0, exp_n, exp_rise;
        bit busy_bad = 0, en_low = 0, err_seen = 0, prev_mux;
        exp_n    = (s == 0) ? 9 + LOCK + SETTLE : 7 + LOCK;
        exp_rise = (s == 0) ? 8 + LOCK + SETTLE : 0;
        @(negedge clk);
        prev_mux = glb_o[12];
        start_i = 1'b1; sel_i = 2'(s); word0_i = w0; word1_i = w1;
        while (n < 400 && done_n == 0) begin
            @(posedge clk); #1;
            n++;
            start_i = intrude && (n == 3);
            if (intrude && n == 3) begin
                sel_i = 2'((s + 1) % 3); word0_i = ~w0; word1_i = ~w1;
            end
            if (err_o) err_seen = 1;
            if (done_o) done_n = n;
            else if (!busy_o) busy_bad = 1;
            if (!glb_o[bit_of(s)]) en_low = 1;
            if (glb_o[12] && !prev_mux) mux_rise = n;
            prev_mux = glb_o[12];
        end
        start_i = 1'b0;
        e0[s] = w0; e1[s] = w1;
        if (intrude) chk(1, "R2", "start while busy", 0, 0);
        chk(done_n == exp_n, (s == 0) ? "R6" : "R7", "done latency", done_n, exp_n);
        chk(mux_rise == exp_rise, (s == 0) ? "R6" : "R7", "mux rise cycle", mux_rise, exp_rise);
        chk(!busy_bad && !busy_o, "R8", "busy through sequence", {31'd0, busy_bad}, 0);
        chk(en_low && !err_seen, "R4", "target disabled, no error", {30'd0, en_low, err_seen}, 2);
        chk(glb_o[2:0] == 3'b111 && glb_o[12], "R5", "enables and mux after", glb_o, 32'h1007);
        chk_cfg(intrude ? "R2" : "R4");
        @(posedge clk); #1;
        chk(!done_o, "R8", "done single pulse", {31'd0, done_o}, 0);
    endtask

    task automatic run_timeout(input int s);
        int n = 0, err_n = 0, exp_n;
        bit done_seen = 0, mux_before;
        exp_n = (s == 0) ? 6 + TMO : 5 + TMO;
        @(negedge clk);
        mux_before = glb_o[12];
        stuck[bit_of(s)] = 1'b1;
        start_i = 1'b1; sel_i = 2'(s);
        word0_i = 32'hDEAD0000 + s; word1_i = 32'hBEEF0000 + s;
        while (n < 400 && err_n == 0) begin
            @(posedge clk); #1;
            n++;
            start_i = 1'b0;
            if (done_o) done_seen = 1;
            if (err_o) err_n = n;
        end
        e0[s] = 32'hDEAD0000 + s; e1[s] = 32'hBEEF0000 + s;
        chk(err_n == exp_n, "R10", "timeout error cycle", err_n, exp_n);
        chk(!done_seen && !busy_o, "R10", "no done, idle", {30'd0, done_seen, busy_o}, 0);
        chk(glb_o[bit_of(s)] == 1'b1, "R10", "target enabled", glb_o, 32'h1);
        chk(glb_o[12] == ((s == 0) ? 1'b0 : mux_before), "R10", "mux after timeout",
            {31'd0, glb_o[12]}, {31'd0, (s == 0) ? 1'b0 : mux_before});
        @(negedge clk);
        stuck = 3'b000;
        repeat (LOCK + 2) @(posedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] g_snap;
        for (int i = 0; i < 3; i++) begin e0[i] = '0; e1[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(glb_o[2:0] == 3'b111, "R1", "reset enables", glb_o, 32'h7);
        chk(glb_o[12] == 1'b1, "R1", "reset mux", glb_o, 32'h1000);
        chk(!busy_o && !done_o && !err_o, "R1", "reset flags", {29'd0, busy_o, done_o, err_o}, 0);
        chk_cfg("R1");

        // R3/R4/R5/R6/R7: every index, three word patterns
        for (int p = 0; p < 3; p++) begin
            for (int s = 0; s < 3; s++) begin
                logic [31:0] w0;
                w0 = 32'h1000_0000 * (p + 1) + 32'h0101 * s + 32'h5a;
                run_retune(s, w0, ~w0 ^ (32'(p) << 4), 1'b0);
            end
        end

        // R2: start pulse mid-sequence for another index is ignored
        run_retune(1, 32'hCAFE_0001, 32'hF00D_0001, 1'b1);
        run_retune(0, 32'h0BAD_F00D, 32'h600D_CAFE, 1'b1);

        // R9: invalid index 3
        @(negedge clk);
        g_snap = glb_o;
        start_i = 1'b1; sel_i = 2'd3; word0_i = 32'hFFFF_FFFF; word1_i = 32'hFFFF_FFFF;
        @(posedge clk); #1;
        start_i = 1'b0;
        chk(err_o && !busy_o, "R9", "error pulse, not busy", {30'd0, err_o, busy_o}, 2);
        @(posedge clk); #1;
        chk(!err_o, "R9", "error single pulse", {31'd0, err_o}, 0);
        chk(glb_o == g_snap, "R9", "control word unchanged", glb_o, g_snap);
        chk_cfg("R9");

        // R10: lock never reported, bus and memory then CPU
        run_timeout(2);
        run_timeout(1);
        run_timeout(0);
        chk_cfg("R10");
        // CPU retune after the parked timeout restores the PLL clock
        run_retune(0, 32'h1357_9BDF, 32'h2468_ACE0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule